// File: doc/BRIEF.md
# Vsync-Latched Window Shadow Register Bank

This block holds the configuration of five display overlay windows in two copies. Software writes and reads a pending copy over a simple flat-addressed register port. The display pipeline sees only the active copy. The active copy takes the pending values only on the rising edge of the vertical-sync input. This means a window never shows a mix of old and new settings partway through a frame.

Each window has a protect bit. While the bit is set, that window's active copy is frozen at every vsync edge, whatever has been written to its pending copy. Software sets the protect bit, rewrites several registers, then clears the bit. The whole group then reaches the active copy together at the first vsync edge after the clear. The block also reports the active window-enable and channel-enable bits of every window as separate outputs.

Top module: `win_shadow_bank`

## Requirements
- R1: After reset, every active register, every pending register and all protect bits are zero, and `act_en_o` and `act_chan_en_o` are zero.
- R2: A read (`rd_en_i` high for one cycle) returns the pending copy of the addressed register on `rdata_o` one cycle later. A write changes the pending copy but not the active copy.
- R3: The active copy never changes except on a clock edge where `vsync_i` is high and was low on the previous edge.
- R4: On a vsync rising edge, every unprotected window copies all four of its pending registers into its active registers in the same cycle.
- R5: On a vsync rising edge, a window whose protect bit was set before that edge keeps all of its active registers unchanged.
- R6: Clearing a protect bit does not by itself update the active copy. The pending values move at the next vsync rising edge after the clear.
- R7: When a write and a vsync rising edge fall in the same cycle, the write goes only to the pending copy. An unprotected window's active copy takes the pre-write value, and the written value moves at the following vsync edge.
- R8: In each window's control register, bit 0 is window enable and bit 1 is channel enable. These bits appear on `act_en_o` and `act_chan_en_o` from the active copy. Clearing the window enable in the pending copy turns the output off only at the next vsync edge.
- R9: Address map: window w, register r (0 control, 1 top-left, 2 bottom-right, 3 buffer base) sits at byte address 16*w + 4*r. Bits [4:0] of the word at 0x50 hold the protect bits of windows 0 to 4, and changes to them take effect at once. An address whose bits [1:0] are not zero, or that matches no register, ignores writes and reads as zero.
- R10: Holding `vsync_i` high for many cycles causes exactly one transfer. Writes made while it stays high wait for the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after `rd_en_i` |
| vsync_i | input | 1 | Vertical sync level; its rising edge triggers the transfer |
| act_cfg_o | output | NUM_WIN*4*DATA_W | Active registers, window w register r at bits [(4w+r)*DATA_W +: DATA_W] |
| act_en_o | output | NUM_WIN | Active window-enable bit of each window |
| act_chan_en_o | output | NUM_WIN | Active channel-enable bit of each window |

## Verification
A corrupted pending copy stays hidden from the display outputs until the next vsync rising edge. It shows on `rdata_o` one cycle after a read of the register, and on `act_cfg_o` one cycle after the edge. A wrong protect or edge-detect state shows on `act_cfg_o` at the very edge where it matters: either a protected window changes, an unprotected window fails to change, or a held vsync level transfers twice. The tests therefore compare all twenty active words against an independent model after every vsync stimulus, and read back pending values to expose write-path faults before any transfer.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // 16-byte stride per window, 4-byte registers
  localparam int REGS_PER_WIN = 4;
  localparam int WIN_STRIDE_B = 16;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_ORIGIN  = 2'd1,
    REG_EXTENT  = 2'd2,
    REG_FBBASE  = 2'd3
  } win_reg_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CHAN_BIT = 1;
endpackage

// File: rtl/swb_addr_decode.sv
module swb_addr_decode
  import swb_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 8
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_WIN-1:0] win_sel_o,
  output win_reg_e           reg_o,
  output logic               prot_hit_o
);
  localparam int WORD_W    = ADDR_W - 2;
  localparam int WIN_IDX_W = WORD_W - 2;
  localparam int PROT_WORD = NUM_WIN * REGS_PER_WIN;

  logic              aligned;
  logic [WORD_W-1:0] word;
  logic [WIN_IDX_W-1:0] win_idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];
  assign win_idx = word[WORD_W-1:2];
  assign reg_o   = win_reg_e'(word[1:0]);
  assign prot_hit_o = aligned && (word == WORD_W'(PROT_WORD));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_sel
    assign win_sel_o[w] = aligned && (win_idx == WIN_IDX_W'(w));
  end
endmodule

// File: rtl/swb_vsync_edge.sv
module swb_vsync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  output logic rise_o
);
  logic vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= vsync_i;
  end

  assign rise_o = vsync_i & ~vs_q;
endmodule

// File: rtl/swb_window.sv
module swb_window
  import swb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en_i,
  input  win_reg_e                           reg_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  input  logic                               xfer_i,
  output logic [REGS_PER_WIN-1:0][DATA_W-1:0] vis_o,
  output logic [REGS_PER_WIN-1:0][DATA_W-1:0] act_o
);
  logic [REGS_PER_WIN-1:0][DATA_W-1:0] vis_q, vis_nxt;
  logic [REGS_PER_WIN-1:0][DATA_W-1:0] act_q, act_nxt;
  logic vis_ld, act_ld;

  assign vis_ld = wr_en_i;
  assign act_ld = xfer_i;

  always_comb begin
    vis_nxt = vis_q;
    if (wr_en_i) vis_nxt[reg_i] = wdata_i;
    // transfer takes the pending value held before this edge
    act_nxt = vis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vis_q <= '0;
    else if (vis_ld) vis_q <= vis_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_ld) act_q <= act_nxt;
  end

  assign vis_o = vis_q;
  assign act_o = act_q;
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import swb_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en_i,
  input  logic                                rd_en_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [DATA_W-1:0]                   rdata_o,
  input  logic                                vsync_i,
  output logic [NUM_WIN*REGS_PER_WIN*DATA_W-1:0] act_cfg_o,
  output logic [NUM_WIN-1:0]                  act_en_o,
  output logic [NUM_WIN-1:0]                  act_chan_en_o
);
  localparam int WIN_BITS = REGS_PER_WIN * DATA_W;

  logic [NUM_WIN-1:0] win_sel;
  win_reg_e           reg_sel;
  logic               prot_hit;
  logic               vs_rise;

  logic [NUM_WIN-1:0] prot_q, prot_nxt;
  logic               prot_ld;
  logic [DATA_W-1:0]  rdata_q, rdata_nxt;
  logic               rdata_ld;

  logic [REGS_PER_WIN-1:0][DATA_W-1:0] vis_arr [NUM_WIN];
  logic [REGS_PER_WIN-1:0][DATA_W-1:0] act_arr [NUM_WIN];
  logic [NUM_WIN*WIN_BITS-1:0]         vis_flat;

  swb_addr_decode #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .win_sel_o  (win_sel),
    .reg_o      (reg_sel),
    .prot_hit_o (prot_hit)
  );

  swb_vsync_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync_i (vsync_i),
    .rise_o  (vs_rise)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic win_wr, win_xfer;
    assign win_wr   = wr_en_i & win_sel[w];
    assign win_xfer = vs_rise & ~prot_q[w];

    swb_window #(.DATA_W(DATA_W)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (win_wr),
      .reg_i   (reg_sel),
      .wdata_i (wdata_i),
      .xfer_i  (win_xfer),
      .vis_o   (vis_arr[w]),
      .act_o   (act_arr[w])
    );

    assign vis_flat[w*WIN_BITS +: WIN_BITS]  = vis_arr[w];
    assign act_cfg_o[w*WIN_BITS +: WIN_BITS] = act_arr[w];
    assign act_en_o[w]      = act_arr[w][REG_CTRL][CTRL_EN_BIT];
    assign act_chan_en_o[w] = act_arr[w][REG_CTRL][CTRL_CHAN_BIT];
  end

  // protect bits: immediate, not shadowed
  assign prot_ld = wr_en_i & prot_hit;
  always_comb begin
    prot_nxt = wdata_i[NUM_WIN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= '0;
    else if (prot_ld) prot_q <= prot_nxt;
  end

  // read path returns the pending copy
  assign rdata_ld = rd_en_i;
  always_comb begin
    rdata_nxt = '0;
    if (prot_hit) rdata_nxt = DATA_W'(prot_q);
    for (int w = 0; w < NUM_WIN; w++) begin
      if (win_sel[w]) rdata_nxt = vis_arr[w][reg_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_ld) rdata_q <= rdata_nxt;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/win_shadow_bank_chk.sv
module win_shadow_bank_chk #(
  parameter int NUM_WIN  = 5,
  parameter int WIN_BITS = 128
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        vsync_i,
  input logic [NUM_WIN-1:0]          prot_q,
  input logic [NUM_WIN*WIN_BITS-1:0] vis_flat,
  input logic [NUM_WIN*WIN_BITS-1:0] act_flat,
  input logic [NUM_WIN-1:0]          act_en_o
);
  logic vs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_prev <= 1'b0;
    else        vs_prev <= vsync_i;
  end

  // R1: clean state right after reset
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (act_flat == '0 && vis_flat == '0 && prot_q == '0));

  // R3 / R10: no vsync rising edge, no active change
  assert_hold_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(vsync_i && !vs_prev) |=> $stable(act_flat));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R4: unprotected window takes its pending copy at the edge
    assert_xfer_unprot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync_i && !vs_prev && !prot_q[w]) |=>
        (act_flat[w*WIN_BITS +: WIN_BITS] == $past(vis_flat[w*WIN_BITS +: WIN_BITS])));

    // R5: protected window holds
    assert_prot_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      prot_q[w] |=> $stable(act_flat[w*WIN_BITS +: WIN_BITS]));

    // R8: enable output drops only at a vsync edge
    assert_en_fall_at_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_en_o[w]) |-> $past(vsync_i && !vs_prev));
  end
endmodule

bind win_shadow_bank win_shadow_bank_chk #(
  .NUM_WIN  (NUM_WIN),
  .WIN_BITS (WIN_BITS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vsync_i  (vsync_i),
  .prot_q   (prot_q),
  .vis_flat (vis_flat),
  .act_flat (act_cfg_o),
  .act_en_o (act_en_o)
);

// File: tb/win_shadow_bank_tb.sv
module win_shadow_bank_tb;
  localparam int NW = 5;
  localparam int DW = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en_i, rd_en_i, vsync_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i, rdata_o;
  logic [NW*4*DW-1:0] act_cfg_o;
  logic [NW-1:0] act_en_o, act_chan_en_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] exp_vis [NW][4];
  logic [DW-1:0] exp_act [NW][4];
  logic [NW-1:0] exp_prot;

  always #5 clk = ~clk;

  win_shadow_bank #(.NUM_WIN(NW), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .vsync_i(vsync_i),
    .act_cfg_o(act_cfg_o), .act_en_o(act_en_o), .act_chan_en_o(act_chan_en_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---- independent model ----
  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int word;
    word = int'(a >> 2);
    if (a[1:0] == 2'b00) begin
      if (word < NW*4) exp_vis[word/4][word%4] = d;
      else if (word == NW*4) exp_prot = d[NW-1:0];
    end
  endtask

  task automatic model_vsync();
    for (int w = 0; w < NW; w++)
      if (!exp_prot[w])
        for (int r = 0; r < 4; r++) exp_act[w][r] = exp_vis[w][r];
  endtask

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    int word;
    word = int'(a >> 2);
    if (a[1:0] != 2'b00) return '0;
    if (word < NW*4) return exp_vis[word/4][word%4];
    if (word == NW*4) return DW'(exp_prot);
    return '0;
  endfunction

  // ---- bus tasks ----
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic read_chk(input string tag, input logic [AW-1:0] a);
    logic [DW-1:0] d;
    bus_read(a, d);
    chk(tag, d, model_read(a));
  endtask

  task automatic pulse_vsync();
    @(negedge clk);
    vsync_i = 1'b1;
    @(negedge clk);
    vsync_i = 1'b0;
    model_vsync();
  endtask

  task automatic check_active(input string tag);
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < 4; r++)
        chk(tag, act_cfg_o[(w*4+r)*DW +: DW], exp_act[w][r]);
      chk({tag, "/R8 en"}, DW'(act_en_o[w]), DW'(exp_act[w][0][0]));
      chk({tag, "/R8 chan"}, DW'(act_chan_en_o[w]), DW'(exp_act[w][0][1]));
    end
  endtask

  function automatic logic [AW-1:0] ra(input int w, input int r);
    return AW'(16*w + 4*r);
  endfunction

  // ---- scenarios ----
  task automatic t_reset();
    check_active("R1 active after reset");
    read_chk("R1 pending ctrl w0", ra(0, 0));
    read_chk("R1 pending base w4", ra(4, 3));
    read_chk("R1 protect", 8'h50);
  endtask

  task automatic t_write_read();
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++)
        bus_write(ra(w, r), 32'hA000_0000 | (w << 8) | (r << 4) | (r == 0 ? 3 : 0));
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++)
        read_chk("R2/R9 readback", ra(w, r));
    check_active("R2 active untouched by writes");
  endtask

  task automatic t_transfer();
    pulse_vsync();
    check_active("R4 transfer all windows");
    bus_write(ra(2, 1), 32'h0011_2233);
    repeat (6) @(negedge clk);
    check_active("R3 no edge no change");
  endtask

  task automatic t_protect();
    bus_write(8'h50, 32'h0000_000A);
    read_chk("R9 protect readback", 8'h50);
    for (int w = 0; w < NW; w++) bus_write(ra(w, 2), 32'hB000_0000 | w);
    pulse_vsync();
    check_active("R5 protected windows 1,3 hold");
    bus_write(8'h50, 32'h0);
    repeat (3) @(negedge clk);
    check_active("R6 unprotect alone no transfer");
    pulse_vsync();
    check_active("R6 transfer after unprotect");
  endtask

  task automatic t_same_cycle();
    bus_write(ra(2, 3), 32'h1234_0000);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = ra(2, 3); wdata_i = 32'h5678_0000; vsync_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; vsync_i = 1'b0;
    model_vsync();
    model_write(ra(2, 3), 32'h5678_0000);
    chk("R7 active takes pre-write value", act_cfg_o[(2*4+3)*DW +: DW], 32'h1234_0000);
    check_active("R7 same-cycle unprotected");
    pulse_vsync();
    check_active("R7 written value at next edge");
    // protected window 0
    bus_write(8'h50, 32'h1);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = ra(0, 1); wdata_i = 32'hCAFE_0001; vsync_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0; vsync_i = 1'b0;
    model_vsync();
    model_write(ra(0, 1), 32'hCAFE_0001);
    check_active("R7 same-cycle protected");
    read_chk("R7 protected pending holds write", ra(0, 1));
    bus_write(8'h50, 32'h0);
  endtask

  task automatic t_disable();
    bus_write(ra(4, 0), 32'h3);
    pulse_vsync();
    chk("R8 enable on", DW'(act_en_o[4]), 32'h1);
    bus_write(ra(4, 0), 32'h0);
    repeat (4) @(negedge clk);
    chk("R8 enable held until vsync", DW'(act_en_o[4]), 32'h1);
    chk("R8 channel held until vsync", DW'(act_chan_en_o[4]), 32'h1);
    pulse_vsync();
    chk("R8 enable off after vsync", DW'(act_en_o[4]), 32'h0);
    chk("R8 channel off after vsync", DW'(act_chan_en_o[4]), 32'h0);
    check_active("R8 full state");
  endtask

  task automatic t_vsync_level();
    bus_write(ra(1, 0), 32'h0000_0001);
    @(negedge clk);
    vsync_i = 1'b1;
    @(negedge clk);
    model_vsync();
    check_active("R10 first edge transfers");
    bus_write(ra(1, 0), 32'h0000_0002);
    repeat (4) @(negedge clk);
    check_active("R10 held level no second transfer");
    vsync_i = 1'b0;
    pulse_vsync();
    check_active("R10 next rising edge transfers");
  endtask

  task automatic t_addr_map();
    bus_write(8'h05, 32'hDEAD_BEEF);
    read_chk("R9 unaligned write ignored", ra(0, 1));
    read_chk("R9 unaligned read zero", 8'h05);
    bus_write(8'h54, 32'hFFFF_FFFF);
    bus_write(8'hFC, 32'hFFFF_FFFF);
    read_chk("R9 unmapped read zero", 8'h54);
    read_chk("R9 unmapped high read zero", 8'hFC);
    read_chk("R9 protect untouched", 8'h50);
    pulse_vsync();
    check_active("R9 no stray writes");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0; vsync_i = 1'b0;
    addr_i = '0; wdata_i = '0;
    exp_prot = '0;
    for (int w = 0; w < NW; w++)
      for (int r = 0; r < 4; r++) begin
        exp_vis[w][r] = '0;
        exp_act[w][r] = '0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_transfer();
    t_protect();
    t_same_cycle();
    t_disable();
    t_vsync_level();
    t_addr_map();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule